// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block lets synchronous logic reach an external asynchronous static RAM of 64K words of 16 bits. A client presents one request at a time: a strobe, a read/write flag, a word address, write data and a per-byte lane-enable mask. The controller turns that request into a correctly timed sequence on the memory's active-low strobes (chip select, write enable, output enable and one strobe per byte lane). It also sends out the address and the write data, and it enables the data-bus drivers. Every timing minimum is turned into a clock-cycle count from a clock-period parameter. Each count is rounded up, so no minimum is ever undercut.

Writes are controlled by write enable. Chip select and the lane strobes fall one cycle before write enable. The address holds steady for as long as write enable is low, and output enable stays high for the whole write, so the shorter write pulse is allowed. The data bus is driven only from the second cycle of the write pulse until write enable rises. After a read, the controller stays idle for the output float time before it accepts new work. Each request ends with a one-cycle `done` pulse. For a read, the captured word comes with that pulse.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After a synchronous reset, chip select, write enable, output enable and both lane strobes are high, `mem_dq_oe` is 0, `done` is 0 and `req_ready` is 1.
- R2: Whenever chip select is high, write enable and output enable are also high and the data bus is not driven.
- R3: A read holds chip select and output enable low and write enable high. It pulls low only the lane strobes whose `req_lanes` bit is 1 (bit 0 is data bits 7:0, bit 1 is bits 15:8). `done` rises N_RD+1 cycles after acceptance, where N_RD = max(ceil(T_AA/CLK_NS), ceil(T_RC/CLK_NS)). `rdata` then holds the memory word, with the bits of disabled lanes forced to zero.
- R4: A write holds chip select and its lane strobes low for one cycle before write enable falls. The address does not change while a write overlap (chip select, write enable and at least one lane strobe all low) is active.
- R5: Output enable stays high for as long as write enable is low.
- R6: Write enable stays low for N_WP = max(ceil(T_WP/CLK_NS), ceil(T_DW/CLK_NS)+1) cycles. `mem_dq_oe` is 1 only while write enable is low, starting one cycle after it falls, so data is valid at least T_DW before the end of the write. `done` rises N_WP+1 cycles after acceptance.
- R7: A write changes only the byte lanes whose `req_lanes` bit is 1; the other byte of the word keeps its old value.
- R8: A request with `req_lanes` = 00 causes no strobe activity. It completes with `done` one cycle after acceptance and `rdata` = 0, and it leaves memory unchanged.
- R9: After a read's `done`, `req_ready` returns after ceil(T_HZ/CLK_NS) cycles. After a write's `done`, it returns after max(1, ceil(T_WC/CLK_NS)-1-N_WP) cycles. A request is accepted only in a cycle where `req_valid` and `req_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_lanes | input | DATA_W/8 | Active-high byte lane mask |
| req_ready | output | 1 | Controller idle, request can be taken |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Read word, valid with `done` of a read |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lane_n | output | DATA_W/8 | Byte lane strobes, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data to the bus drivers |
| mem_dq_oe | output | 1 | Bus driver enable |
| mem_dq_in | input | DATA_W | Data from the bus |

## Verification
The hardest case to reach is a partial-lane write followed by a read of the same word. A fault there shows up only if the byte that was not written comes back unchanged, and only if a disabled lane's junk on the bus is masked. A behavioural memory model in the bench drives unrelated junk on every lane that is not enabled. The same model measures, at each write's end, the pulse length, the data setup and the address stability. The stimulus mixes directed merges of the two lanes at fixed addresses with seeded random reads and writes over a small address pool. Back-to-back read-then-write pairs therefore occur often, and so do mask-zero requests.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACCESS,
        ST_RD_CAPTURE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_RECOVER
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic we_n;
        logic oe_n;
    } mem_ctl_t;

    localparam mem_ctl_t CTL_QUIET = '{cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};

    // Round a nanosecond minimum up to whole clock cycles, at least one.
    function automatic int ns_to_cycles(input int t_ns, input int clk_ns);
        int c;
        c = (t_ns + clk_ns - 1) / clk_ns;
        if (c < 1) c = 1;
        return c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // States in which the memory is selected.
    function automatic logic is_selected(input seq_state_e s);
        return (s == ST_RD_ACCESS) || (s == ST_RD_CAPTURE) ||
               (s == ST_WR_SETUP)  || (s == ST_WR_PULSE);
    endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R6: a running wait always steps down by exactly one
    p_tick_down_r6: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_lane_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int N_RD     = 8,
    parameter int N_WP     = 5,
    parameter int N_REC_RD = 2,
    parameter int N_REC_WR = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             req_any_lane,
    input  logic             t_zero,
    output seq_state_e       state_q,
    output seq_state_e       state_d,
    output logic             t_load,
    output logic [CNT_W-1:0] t_val,
    output logic             accept,
    output logic             null_accept
);
    localparam logic [CNT_W-1:0] V_RD  = CNT_W'(N_RD - 1);
    localparam logic [CNT_W-1:0] V_WP  = CNT_W'(N_WP - 1);
    localparam logic [CNT_W-1:0] V_RRD = CNT_W'(N_REC_RD - 1);
    localparam logic [CNT_W-1:0] V_RWR = CNT_W'(N_REC_WR - 1);

    always_comb begin
        state_d     = state_q;
        t_load      = 1'b0;
        t_val       = '0;
        accept      = 1'b0;
        null_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept = 1'b1;
                    if (!req_any_lane) begin
                        null_accept = 1'b1;
                    end else if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d = ST_RD_ACCESS;
                        t_load  = 1'b1;
                        t_val   = V_RD;
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (t_zero) state_d = ST_RD_CAPTURE;
            end
            ST_RD_CAPTURE: begin
                state_d = ST_RECOVER;
                t_load  = 1'b1;
                t_val   = V_RRD;
            end
            ST_WR_SETUP: begin
                state_d = ST_WR_PULSE;
                t_load  = 1'b1;
                t_val   = V_WP;
            end
            ST_WR_PULSE: begin
                if (t_zero) begin
                    state_d = ST_RECOVER;
                    t_load  = 1'b1;
                    t_val   = V_RWR;
                end
            end
            ST_RECOVER: begin
                if (t_zero) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // R8: an empty lane mask never leaves the idle state
    p_null_stays_idle_r8: assert property (@(posedge clk) disable iff (rst)
        null_accept |=> (state_q == ST_IDLE));

    // R4: the write pulse is always preceded by the setup state
    p_setup_first_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WR_PULSE) |-> ($past(state_q) inside {ST_WR_SETUP, ST_WR_PULSE}));

    // R9: recovery always ends in idle, never straight into a new cycle
    p_recover_to_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RECOVER) |=> (state_q inside {ST_RECOVER, ST_IDLE}));

endmodule

// File: rtl/sram_pin_drive.sv
module sram_pin_drive
    import sram_lane_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  seq_state_e        state_q,
    input  seq_state_e        state_d,
    input  logic              accept,
    input  logic              null_accept,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [LANES-1:0]  req_lanes,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [LANES-1:0]  mem_lane_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    mem_ctl_t          ctl_q, ctl_d;
    logic [LANES-1:0]  lanes_q, lane_src, lane_n_d;
    logic [DATA_W-1:0] cap_word;
    logic              sel_d, dq_oe_d, done_d;
    logic              take_req;

    assign take_req = accept && !null_accept;
    assign lane_src = take_req ? req_lanes : lanes_q;
    assign sel_d    = is_selected(state_d);

    always_comb begin
        ctl_d.cs_n = !sel_d;
        ctl_d.we_n = !(state_d == ST_WR_PULSE);
        ctl_d.oe_n = !((state_d == ST_RD_ACCESS) || (state_d == ST_RD_CAPTURE));
    end

    assign dq_oe_d = (state_d == ST_WR_PULSE) && (state_q == ST_WR_PULSE);
    assign done_d  = null_accept || (state_q == ST_RD_CAPTURE) ||
                     ((state_q == ST_WR_PULSE) && (state_d == ST_RECOVER));

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_n_d[g]       = !(sel_d && lane_src[g]);
        assign cap_word[g*8 +: 8] = lanes_q[g] ? mem_dq_in[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q      <= CTL_QUIET;
            mem_lane_n <= '1;
            mem_dq_oe  <= 1'b0;
            done       <= 1'b0;
            lanes_q    <= '0;
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rdata      <= '0;
        end else begin
            ctl_q      <= ctl_d;
            mem_lane_n <= lane_n_d;
            mem_dq_oe  <= dq_oe_d;
            done       <= done_d;
            if (take_req) begin
                lanes_q    <= req_lanes;
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (null_accept)                   rdata <= '0;
            else if (state_q == ST_RD_CAPTURE) rdata <= cap_word;
        end
    end

    assign mem_cs_n = ctl_q.cs_n;
    assign mem_we_n = ctl_q.we_n;
    assign mem_oe_n = ctl_q.oe_n;

    // R2: a deselected memory sees no other active strobe and no driven bus
    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        mem_cs_n |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

    // R4: the address cannot move while write enable is low
    p_addr_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |=> $stable(mem_addr));

    // R4: write enable falls only after a cycle with chip select already low
    p_cs_before_we_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_we_n) |-> $past(!mem_cs_n));

    // R5: output enable stays high during the write pulse
    p_oe_off_in_write_r5: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> mem_oe_n);

    // R6: the bus drivers are on only inside the write pulse
    p_bus_window_r6: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && $past(!mem_we_n)));

    // R3: a read selects at least one lane
    p_read_has_lane_r3: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> ($countones(~mem_lane_n) >= 1));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_lane_pkg::*;
#(
    parameter int CLK_NS = 20,
    parameter int T_AA   = 150,
    parameter int T_RC   = 150,
    parameter int T_WC   = 150,
    parameter int T_WP   = 100,
    parameter int T_DW   = 60,
    parameter int T_HZ   = 30,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_lanes,
    output logic                  req_ready,
    output logic                  done,
    output logic [DATA_W-1:0]     rdata,
    output logic                  mem_cs_n,
    output logic                  mem_we_n,
    output logic                  mem_oe_n,
    output logic [DATA_W/8-1:0]   mem_lane_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);
    localparam int LANES    = DATA_W / 8;
    localparam int N_RD     = imax(ns_to_cycles(T_AA, CLK_NS), ns_to_cycles(T_RC, CLK_NS));
    localparam int N_WP     = imax(ns_to_cycles(T_WP, CLK_NS), ns_to_cycles(T_DW, CLK_NS) + 1);
    localparam int N_REC_RD = ns_to_cycles(T_HZ, CLK_NS);
    localparam int N_REC_WR = imax(1, ns_to_cycles(T_WC, CLK_NS) - 1 - N_WP);
    localparam int CNT_MAX  = imax(imax(N_RD, N_WP), imax(N_REC_RD, N_REC_WR));
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    seq_state_e       state_q, state_d;
    logic             t_load, t_zero, accept, null_accept;
    logic [CNT_W-1:0] t_val;

    sram_wait_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .zero     (t_zero)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .N_RD     (N_RD),
        .N_WP     (N_WP),
        .N_REC_RD (N_REC_RD),
        .N_REC_WR (N_REC_WR)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_any_lane (|req_lanes),
        .t_zero       (t_zero),
        .state_q      (state_q),
        .state_d      (state_d),
        .t_load       (t_load),
        .t_val        (t_val),
        .accept       (accept),
        .null_accept  (null_accept)
    );

    sram_pin_drive #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) u_pins (
        .clk         (clk),
        .rst         (rst),
        .state_q     (state_q),
        .state_d     (state_d),
        .accept      (accept),
        .null_accept (null_accept),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .req_lanes   (req_lanes),
        .mem_dq_in   (mem_dq_in),
        .mem_cs_n    (mem_cs_n),
        .mem_we_n    (mem_we_n),
        .mem_oe_n    (mem_oe_n),
        .mem_lane_n  (mem_lane_n),
        .mem_addr    (mem_addr),
        .mem_dq_out  (mem_dq_out),
        .mem_dq_oe   (mem_dq_oe),
        .done        (done),
        .rdata       (rdata)
    );

    assign req_ready = (state_q == ST_IDLE);

    // R9: a request is only taken while the controller reports ready
    p_accept_when_ready_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> $stable(mem_addr));

endmodule

// File: tb/test_sram_lane_ctrl.sv
module test_sram_lane_ctrl;
    localparam int CLK_NS = 5;
    localparam int B_RD   = 30;
    localparam int B_WP   = 20;
    localparam int B_TA   = 6;
    localparam int B_RECW = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0, req_wdata = '0;
    logic [1:0]  req_lanes = '0;
    logic        req_ready, done;
    logic [15:0] rdata;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_addr, mem_dq_out;
    logic [15:0] mem_dq_in = '0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    sram_lane_ctrl #(.CLK_NS(CLK_NS)) i_sram_lane_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
        .req_ready(req_ready), .done(done), .rdata(rdata),
        .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_lane_n(mem_lane_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
        .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural memory model ----------------
    logic [15:0] model_mem [logic [15:0]];
    logic [15:0] exp_mem   [logic [15:0]];
    logic        wr_now, wr_prev = 1'b0, rd_now;
    logic [15:0] addr_prev = '0, last_data = '0, last_addr = '0, mdl_word;
    logic [1:0]  last_lanes = '0;
    int          pulse_cnt = 0, setup_cnt = 0;

    assign wr_now = !mem_cs_n && !mem_we_n && (mem_lane_n != 2'b11);
    assign rd_now = !mem_cs_n && mem_we_n && !mem_oe_n;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_prev && wr_now && mem_addr != addr_prev)
                chk(1'b0, "R4 address moved in write", 32'(mem_addr), 32'(addr_prev));
            if (!mem_we_n && !mem_oe_n)
                chk(1'b0, "R5 oe low in write", 32'(mem_oe_n), 32'd1);
            if (mem_cs_n && (!mem_we_n || !mem_oe_n || mem_dq_oe))
                chk(1'b0, "R2 strobe while deselected", {mem_we_n, mem_oe_n, mem_dq_oe}, 32'b110);
            if (mem_dq_oe && mem_we_n)
                chk(1'b0, "R6 bus driven outside pulse", 32'(mem_we_n), 32'd0);
            if (wr_now) begin
                pulse_cnt++;
                setup_cnt  = mem_dq_oe ? setup_cnt + 1 : 0;
                last_data  = mem_dq_out;
                last_lanes = ~mem_lane_n;
                last_addr  = mem_addr;
            end else if (wr_prev) begin
                chk(pulse_cnt * CLK_NS >= 100, "R6 write pulse length", 32'(pulse_cnt), 32'(B_WP));
                chk(setup_cnt * CLK_NS >= 60, "R6 data setup", 32'(setup_cnt), 32'd12);
                mdl_word = model_mem.exists(last_addr) ? model_mem[last_addr] : 16'h0;
                if (last_lanes[0]) mdl_word[7:0]  = last_data[7:0];
                if (last_lanes[1]) mdl_word[15:8] = last_data[15:8];
                model_mem[last_addr] = mdl_word;
                pulse_cnt = 0;
                setup_cnt = 0;
            end
            wr_prev   = wr_now;
            addr_prev = mem_addr;
            mdl_word  = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0;
            mem_dq_in[7:0]  <= (rd_now && !mem_lane_n[0]) ? mdl_word[7:0]  : (8'h5A ^ mem_addr[7:0]);
            mem_dq_in[15:8] <= (rd_now && !mem_lane_n[1]) ? mdl_word[15:8] : (8'hC3 ^ mem_addr[15:8]);
        end
    end

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cycles++;
        if (cycles == 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [15:0] exp_read(input logic [15:0] a, input logic [1:0] ln);
        logic [15:0] w;
        w = exp_mem.exists(a) ? exp_mem[a] : 16'h0;
        return {ln[1] ? w[15:8] : 8'h00, ln[0] ? w[7:0] : 8'h00};
    endfunction

    task automatic run_op(input bit wr, input logic [15:0] a, input logic [15:0] d, input logic [1:0] ln);
        int lat, rec, exp_lat, exp_rec;
        logic [15:0] w;
        while (!req_ready) @(negedge clk);
        req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        exp_lat = (ln == 2'b00) ? 1 : (wr ? B_WP + 2 : B_RD + 2);
        if (ln == 2'b00) begin
            chk(lat == exp_lat, "R8 null latency", 32'(lat), 32'(exp_lat));
            chk(rdata == 16'h0 && mem_cs_n && mem_lane_n == 2'b11, "R8 null result", 32'(rdata), 32'h0);
        end else if (wr) begin
            chk(lat == exp_lat, "R6 write latency", 32'(lat), 32'(exp_lat));
            w = exp_mem.exists(a) ? exp_mem[a] : 16'h0;
            if (ln[0]) w[7:0]  = d[7:0];
            if (ln[1]) w[15:8] = d[15:8];
            exp_mem[a] = w;
        end else begin
            chk(lat == exp_lat, "R3 read latency", 32'(lat), 32'(exp_lat));
            chk(rdata == exp_read(a, ln), "R3 R7 read data", 32'(rdata), 32'(exp_read(a, ln)));
        end
        rec = 0;
        while (!req_ready) begin
            @(negedge clk);
            rec++;
        end
        exp_rec = (ln == 2'b00) ? 0 : (wr ? B_RECW : B_TA);
        chk(rec == exp_rec, "R9 recovery", 32'(rec), 32'(exp_rec));
    endtask

    initial begin
        int unsigned seed_v;
        seed_v = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(mem_cs_n && mem_we_n && mem_oe_n && mem_lane_n == 2'b11 && !mem_dq_oe,
            "R1 strobes", {mem_cs_n, mem_we_n, mem_oe_n, mem_lane_n, mem_dq_oe}, 32'b111110);
        chk(!done && req_ready, "R1 handshake", {done, req_ready}, 32'b01);

        // directed corners
        run_op(1'b1, 16'hFFFF, 16'hBEEF, 2'b11);
        run_op(1'b0, 16'hFFFF, 16'h0000, 2'b11);
        run_op(1'b1, 16'h0000, 16'h1234, 2'b01);   // R7 low lane only
        run_op(1'b1, 16'h0000, 16'hABCD, 2'b10);   // R7 high lane only
        run_op(1'b0, 16'h0000, 16'h0000, 2'b11);   // expect AB34
        run_op(1'b0, 16'h0000, 16'h0000, 2'b10);   // R3 masked low lane
        run_op(1'b0, 16'h0000, 16'h0000, 2'b01);   // R3 masked high lane
        run_op(1'b1, 16'h0000, 16'h5555, 2'b00);   // R8 no write
        run_op(1'b0, 16'h0000, 16'h0000, 2'b00);   // R8 null read
        run_op(1'b0, 16'h0000, 16'h0000, 2'b11);   // R8 memory unchanged

        // seeded random mix
        for (int i = 0; i < 60; i++) begin
            logic [15:0] a;
            logic [1:0]  ln;
            bit          wr;
            a  = {13'h1A5C, 3'($urandom())};
            ln = 2'($urandom());
            wr = ($urandom() % 2) == 0;
            run_op(wr, a, 16'($urandom()), ln);
        end

        for (int i = 0; i < 8; i++) run_op(1'b0, {13'h1A5C, 3'(i)}, 16'h0, 2'b11);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule